// File: doc/BRIEF.md
# Evolvable 3x3 Pixel Filter Array

This block turns a 3x3 window of 8-bit pixels into one filtered 8-bit pixel. Nine small processing elements (PEs) form a feed-forward grid of three columns with three PEs each. A 112-bit configuration word, the chromosome, sets three things: the two operand sources of every PE, the operation that each PE applies, and the PE that drives the result. An outside search process can try many filter structures by writing chromosomes. The datapath stays fixed; only the register contents change.

The chromosome is stored when the load strobe is high. A window marked valid is computed against the stored chromosome and comes out one clock later, with a valid flag. PE sources may only point at filter inputs or at PEs in earlier columns, so no combinational loop can form, whatever the configuration.

Top module: `filt_pe_array`

## Requirements
- R1: On a clock edge with `load_i` high, `chrom_i` is stored. With `load_i` low the stored chromosome does not change. A window sampled on the same edge as a load uses the chromosome stored before that edge.
- R2: PE k (k = 0..8) reads its gene from chromosome bits [12k+11:12k]. Within a gene, bits [11:8] select operand A, bits [7:4] select operand B and bits [3:0] give the operation. Bits [111:108] select the output PE.
- R3: Source codes 0..8 select filter pixel n, where pixel n sits on `pix_i` bits [8n+7:8n]. Pixel 0 is the centre pixel.
- R4: PEs are numbered column-major, so PE k is in column k/3. Source codes 9..14 select the output of PE (code-9), but only when that PE is in an earlier column than the reading PE.
- R5: Source code 15, or a code 9..14 that names a PE in the same or a later column, selects pixel 0.
- R6: Operation codes 0..7 give 255, A, 255-A, A|B, A|B, A&B, ~(A&B) and A^B.
- R7: Operation codes 8, 9 and 10 give A>>1, A>>2 and A with its two nibbles swapped.
- R8: Code 11 gives A+B modulo 256. Code 12 gives A+B clamped to 255. Code 13 gives bits [8:1] of the 9-bit sum A+B.
- R9: Code 14 gives max(A,B) and code 15 gives min(A,B).
- R10: The unary codes 0, 1, 2, 8, 9 and 10 ignore operand B.
- R11: An output select of 0..8 routes that PE to the output. Any value above 8 routes PE 8.
- R12: `out_pix_o` and `out_valid_o` are registered. `out_valid_o` equals `in_valid_i` one cycle earlier. `out_pix_o` holds its value when no window arrives. Reset clears the outputs and the stored chromosome to zero, so an all-zero chromosome yields 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Store `chrom_i` on this edge |
| chrom_i | input | 112 | Chromosome word |
| in_valid_i | input | 1 | Pixel window present |
| pix_i | input | 72 | Nine pixels, pixel n at bits [8n+7:8n] |
| out_pix_o | output | 8 | Filtered pixel |
| out_valid_o | output | 1 | Filtered pixel valid |

## Verification
The bench goes after the arithmetic edges where a wrong width shows at once: 200+100 must wrap to 44, saturation must stop at 255, and the average of 255 and 255 must stay 255 instead of dropping its carry to give 127. It checks the column rule by pointing PEs at their own column, at a later column and at code 15. A design that wired any of these through would return another PE's value in place of the centre pixel. It checks that a window on the same edge as a load still uses the old chromosome, and that an output select above 8 falls back to PE 8 rather than to PE 0 or to an undefined value. Many random chromosome and window pairs are then compared against a bench model of the whole grid.

// File: rtl/filt_pkg.sv
package filt_pkg;

    localparam int PIX_W    = 8;
    localparam int ROWS     = 3;
    localparam int COLS     = 3;
    localparam int NUM_IN   = 9;
    localparam int NUM_PE   = ROWS * COLS;
    localparam int FLD_W    = 4;
    localparam int GENE_W   = 3 * FLD_W;
    localparam int GENES_W  = NUM_PE * GENE_W;
    localparam int CHROM_W  = GENES_W + FLD_W;
    localparam int PE_CODES = (1 << FLD_W) - 1 - NUM_IN;  // codes usable for PE outputs

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [FLD_W-1:0] fld_t;

    typedef enum logic [FLD_W-1:0] {
        OP_ONES = 4'd0,  OP_PASS = 4'd1,  OP_INV  = 4'd2,  OP_OR   = 4'd3,
        OP_OR2  = 4'd4,  OP_AND  = 4'd5,  OP_NAND = 4'd6,  OP_XOR  = 4'd7,
        OP_SHR1 = 4'd8,  OP_SHR2 = 4'd9,  OP_SWAP = 4'd10, OP_ADD  = 4'd11,
        OP_ADDS = 4'd12, OP_AVG  = 4'd13, OP_MAX  = 4'd14, OP_MIN  = 4'd15
    } op_e;

    typedef struct packed {
        fld_t src_a;
        fld_t src_b;
        op_e  op;
    } gene_t;

    function automatic pix_t pe_alu(op_e op, pix_t a, pix_t b);
        logic [PIX_W:0] sum;
        pix_t           r;
        sum = {1'b0, a} + {1'b0, b};
        unique case (op)
            OP_ONES: r = '1;
            OP_PASS: r = a;
            OP_INV:  r = ~a;
            OP_OR,
            OP_OR2:  r = a | b;
            OP_AND:  r = a & b;
            OP_NAND: r = ~(a & b);
            OP_XOR:  r = a ^ b;
            OP_SHR1: r = a >> 1;
            OP_SHR2: r = a >> 2;
            OP_SWAP: r = {a[PIX_W/2-1:0], a[PIX_W-1:PIX_W/2]};
            OP_ADD:  r = sum[PIX_W-1:0];
            OP_ADDS: r = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
            OP_AVG:  r = sum[PIX_W:1];
            OP_MAX:  r = (a > b) ? a : b;
            OP_MIN:  r = (a < b) ? a : b;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/filt_cfg_store.sv
module filt_cfg_store
    import filt_pkg::*;
(
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      load_i,
    input  logic [CHROM_W-1:0]        chrom_i,
    output gene_t [NUM_PE-1:0]        genes_o,
    output fld_t                      osel_o
);

    logic [CHROM_W-1:0] cfg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cfg_q <= '0;
        else if (load_i)
            cfg_q <= chrom_i;
    end

    assign genes_o = cfg_q[GENES_W-1:0];
    assign osel_o  = cfg_q[CHROM_W-1:GENES_W];

    // R1: a strobe captures the word
    p_cfg_load_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cfg_q == $past(chrom_i)));

    // R1: no strobe, no change
    p_cfg_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/filt_pe_cell.sv
module filt_pe_cell
    import filt_pkg::*;
#(
    parameter int COL = 0
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  gene_t                 gene_i,
    input  pix_t [NUM_IN-1:0]     pix_i,
    input  pix_t [NUM_PE-1:0]     pe_i,
    output pix_t                  y_o
);

    localparam int REACH = COL * ROWS;

    pix_t opa, opb;

    function automatic pix_t pick(fld_t code, pix_t [NUM_IN-1:0] px, pix_t [NUM_PE-1:0] pe);
        pix_t v;
        v = px[0];
        for (int k = 0; k < NUM_IN; k++)
            if (code == fld_t'(k)) v = px[k];
        for (int k = 0; k < NUM_PE; k++)
            if (k < REACH && k < PE_CODES && code == fld_t'(NUM_IN + k)) v = pe[k];
        return v;
    endfunction

    always_comb begin
        opa = pick(gene_i.src_a, pix_i, pe_i);
        opb = pick(gene_i.src_b, pix_i, pe_i);
        y_o = pe_alu(gene_i.op, opa, opb);
    end

    // R5: code 15 never reaches a PE output
    p_fallback_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (gene_i.src_a == 4'hF) |-> (opa == pix_i[0]));

    // R9: max returns one of the operands and bounds both
    p_max_bound_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (gene_i.op == OP_MAX) |-> (y_o >= opa && y_o >= opb && (y_o == opa || y_o == opb)));

    // R8: saturating add never falls below an operand
    p_sat_floor_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (gene_i.op == OP_ADDS) |-> (y_o >= opa && y_o >= opb));

    // R10: identity follows operand A alone
    p_pass_a_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (gene_i.op == OP_PASS) |-> (y_o == opa));

endmodule

// File: rtl/filt_pe_array.sv
module filt_pe_array
    import filt_pkg::*;
(
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       load_i,
    input  logic [CHROM_W-1:0]         chrom_i,
    input  logic                       in_valid_i,
    input  logic [NUM_IN*PIX_W-1:0]    pix_i,
    output logic [PIX_W-1:0]           out_pix_o,
    output logic                       out_valid_o
);

    gene_t [NUM_PE-1:0] genes;
    fld_t               osel;
    pix_t [NUM_IN-1:0]  pix_arr;
    pix_t [NUM_PE-1:0]  pe_y;
    pix_t               sel_y;

    assign pix_arr = pix_i;

    filt_cfg_store u_cfg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load_i),
        .chrom_i (chrom_i),
        .genes_o (genes),
        .osel_o  (osel)
    );

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        filt_pe_cell #(.COL(p / ROWS)) u_pe (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .gene_i (genes[p]),
            .pix_i  (pix_arr),
            .pe_i   (pe_y),
            .y_o    (pe_y[p])
        );
    end

    always_comb begin
        sel_y = pe_y[NUM_PE-1];
        for (int k = 0; k < NUM_PE; k++)
            if (osel == fld_t'(k)) sel_y = pe_y[k];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_pix_o   <= '0;
            out_valid_o <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i)
                out_pix_o <= sel_y;
        end
    end

    // R12: one-cycle latency of the valid flag
    p_valid_lat_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (out_valid_o == $past(in_valid_i)));

    // R12: output held between windows
    p_out_hold_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> $stable(out_pix_o));

    // R11: output select range above 8 lands on the last PE
    p_osel_top_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (osel > fld_t'(NUM_PE - 1)) |-> (sel_y == pe_y[NUM_PE-1]));

endmodule

// File: tb/tb_filt_pe_array.sv
`timescale 1ns/1ps
module tb_filt_pe_array;

    logic         clk = 1'b0;
    logic         rst;
    logic         load;
    logic [111:0] chrom;
    logic         in_valid;
    logic [71:0]  pix;
    logic [7:0]   out_pix;
    logic         out_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    filt_pe_array dut (
        .clk_i(clk), .rst_i(rst), .load_i(load), .chrom_i(chrom),
        .in_valid_i(in_valid), .pix_i(pix),
        .out_pix_o(out_pix), .out_valid_o(out_valid)
    );

    function automatic int alu_m(int op, int a, int b);
        case (op)
            0: return 255;
            1: return a;
            2: return 255 - a;
            3, 4: return a | b;
            5: return a & b;
            6: return 255 - (a & b);
            7: return a ^ b;
            8: return a / 2;
            9: return a / 4;
            10: return ((a % 16) * 16) + (a / 16);
            11: return (a + b) % 256;
            12: return (a + b > 255) ? 255 : a + b;
            13: return (a + b) / 2;
            14: return (a > b) ? a : b;
            default: return (a < b) ? a : b;
        endcase
    endfunction

    function automatic int model(logic [111:0] c, logic [71:0] p);
        int pe[9];
        int osel;
        for (int k = 0; k < 9; k++) begin
            int sa, sb, op, va, vb, lim;
            sa  = int'(c[12*k+8 +: 4]);
            sb  = int'(c[12*k+4 +: 4]);
            op  = int'(c[12*k +: 4]);
            lim = (k / 3) * 3;
            if (sa < 9) va = int'(p[8*sa +: 8]);
            else if (sa < 15 && sa - 9 < lim) va = pe[sa - 9];
            else va = int'(p[7:0]);
            if (sb < 9) vb = int'(p[8*sb +: 8]);
            else if (sb < 15 && sb - 9 < lim) vb = pe[sb - 9];
            else vb = int'(p[7:0]);
            pe[k] = alu_m(op, va, vb);
        end
        osel = int'(c[111:108]);
        return (osel > 8) ? pe[8] : pe[osel];
    endfunction

    function automatic logic [111:0] gene(logic [111:0] c, int k, int a, int b, int op);
        logic [111:0] r;
        r = c;
        r[12*k +: 12] = {4'(a), 4'(b), 4'(op)};
        return r;
    endfunction

    function automatic logic [111:0] with_osel(logic [111:0] c, int s);
        logic [111:0] r;
        r = c;
        r[111:108] = 4'(s);
        return r;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_load(logic [111:0] c);
        @(negedge clk);
        chrom = c;
        load  = 1'b1;
        @(negedge clk);
        load  = 1'b0;
    endtask

    task automatic do_win(logic [71:0] p, int exp, string tag);
        pix      = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, int'(out_valid), 1);
        chk(tag, int'(out_pix), exp);
    endtask

    task automatic run(logic [111:0] c, logic [71:0] p, string tag);
        do_load(c);
        do_win(p, model(c, p), tag);
    endtask

    function automatic logic [71:0] rand_pix();
        return {8'($urandom), 32'($urandom), 32'($urandom)};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [71:0]  p;
        logic [111:0] c;
        logic [111:0] z;
        int           hold;
        void'($urandom(32'd20240611));
        z = '0;
        rst = 1'b1; load = 1'b0; in_valid = 1'b0; chrom = '0; pix = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk("R12 reset valid", int'(out_valid), 0);
        chk("R12 reset pix", int'(out_pix), 0);
        p = rand_pix();
        do_win(p, 255, "R12 zero chromosome");

        // R12: hold between windows
        hold = int'(out_pix);
        pix = rand_pix();
        @(negedge clk);
        chk("R12 no-window valid", int'(out_valid), 0);
        chk("R12 hold pix", int'(out_pix), hold);

        // R6 R7 R8 R9: each operation on PE 0 with A=pixel1, B=pixel2
        for (int op = 0; op < 16; op++) begin
            string t;
            t = (op < 8) ? "R6 op" : (op < 11) ? "R7 op" : (op < 14) ? "R8 op" : "R9 op";
            p = rand_pix();
            c = gene(z, 0, 1, 2, op);
            do_load(c);
            do_win(p, alu_m(op, int'(p[15:8]), int'(p[23:16])), $sformatf("%s %0d", t, op));
        end

        // R8: arithmetic edges
        p = '0; p[15:8] = 8'd200; p[23:16] = 8'd100;
        do_load(gene(z, 0, 1, 2, 11)); do_win(p, 44, "R8 add wraps");
        do_load(gene(z, 0, 1, 2, 12)); do_win(p, 255, "R8 add saturates");
        do_load(gene(z, 0, 1, 2, 13)); do_win(p, 150, "R8 average");
        p[15:8] = 8'd255; p[23:16] = 8'd255;
        do_win(p, 255, "R8 average keeps carry");

        // R2 R3: each pixel code through identity
        for (int n = 0; n < 9; n++) begin
            p = rand_pix();
            do_load(gene(z, 0, n, 0, 1));
            do_win(p, int'(p[8*n +: 8]), $sformatf("R3 pixel %0d", n));
        end

        // R10: unary op ignores B
        p = rand_pix();
        do_load(gene(z, 0, 1, 2, 2));
        do_win(p, 255 - int'(p[15:8]), "R10 inversion B=2");
        do_load(gene(z, 0, 1, 5, 2));
        do_win(p, 255 - int'(p[15:8]), "R10 inversion B=5");
        do_load(gene(z, 0, 3, 7, 10));
        do_win(p, alu_m(10, int'(p[31:24]), 0), "R10 swap B=7");

        // R4: PE3 reads PE0, PE8 reads PE5
        p = rand_pix();
        c = gene(gene(z, 0, 1, 0, 2), 3, 9, 0, 1);
        do_load(with_osel(c, 3));
        do_win(p, 255 - int'(p[15:8]), "R4 PE3 reads PE0");
        c = gene(gene(z, 5, 4, 0, 9), 8, 14, 0, 1);
        do_load(with_osel(c, 8));
        do_win(p, int'(p[39:32]) / 4, "R4 PE8 reads PE5");

        // R5: fallbacks to pixel 0
        p = rand_pix();
        do_load(gene(z, 0, 9, 0, 1));
        do_win(p, int'(p[7:0]), "R5 col0 code 9");
        do_load(gene(z, 0, 15, 0, 1));
        do_win(p, int'(p[7:0]), "R5 code 15");
        c = gene(gene(z, 4, 1, 0, 2), 3, 13, 0, 1);
        do_load(with_osel(c, 3));
        do_win(p, int'(p[7:0]), "R5 own column");
        c = gene(gene(z, 6, 2, 0, 1), 2, 14, 0, 1);
        do_load(with_osel(c, 2));
        do_win(p, int'(p[7:0]), "R5 later column");

        // R11: output select
        p = rand_pix();
        c = gene(gene(z, 8, 6, 0, 1), 7, 5, 0, 1);
        do_load(with_osel(c, 7));
        do_win(p, int'(p[47:40]), "R11 select 7");
        do_load(with_osel(c, 15));
        do_win(p, int'(p[55:48]), "R11 select 15 to PE8");
        do_load(with_osel(c, 9));
        do_win(p, int'(p[55:48]), "R11 select 9 to PE8");

        // R1: same-edge load uses the old chromosome; no strobe means no change
        c = gene(z, 0, 1, 0, 1);
        do_load(c);
        p = rand_pix();
        @(negedge clk);
        chrom = gene(z, 0, 2, 0, 1);
        load = 1'b1; pix = p; in_valid = 1'b1;
        @(negedge clk);
        load = 1'b0; in_valid = 1'b0;
        chk("R1 same-edge uses old", int'(out_pix), int'(p[15:8]));
        do_win(p, int'(p[23:16]), "R1 new after load");
        chrom = gene(z, 0, 3, 0, 1);
        @(negedge clk);
        do_win(p, int'(p[23:16]), "R1 no strobe keeps config");

        // random mix
        for (int it = 0; it < 400; it++) begin
            c = {16'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)};
            run(c, rand_pix(), "R2 R4 R11 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule